// File: doc/BRIEF.md
# Page Translation Cache with Software Refill

This block caches virtual-to-physical page translations for a 32-bit virtual address space split into 4 KB pages. Sixteen fully associative slots each hold a virtual page, a physical page, a two-bit permission code, and valid, referenced and modified flags. A lookup presents a virtual address and an access kind. In the same cycle the block answers with one of four outcomes: a translated physical address, a permission fault, a miss trap that carries the page number, or a multi-match error.

On a miss the block never fetches anything itself. The trap tells software to install the translation through a refill port, which names the slot to overwrite. A replacement hint points software at a good slot. It picks the lowest empty slot first, then the lowest slot that has not been referenced. When every slot is both filled and referenced, it clears all reference flags and points at slot 0. A flush input empties the whole cache in one cycle.

The lookup side is a valid/ready stream with no back-pressure on the response. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. The response appears combinationally in that same cycle, marked by `rsp_valid`, and the consumer must take it then. `req_ready` is low in every cycle where a refill or a flush is presented, because maintenance has priority. Flags change on the clock edge that ends the accepted cycle.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit the physical address is the slot's physical page number joined to bits 11:0 of the virtual address, which pass through unchanged; bits 31:12 form the virtual page number.
- R2: A request whose page matches no valid slot asserts `trap_miss` with `trap_vpn` equal to the requested page, and `rsp_hit` stays low.
- R3: Access kinds are 0 read, 1 write, 2 execute. Permission codes are 0 read-only (read), 1 read/write (read, write), 2 read/execute (read, execute) and 3 no access. A disallowed access asserts `rsp_fault`, and it changes neither the referenced nor the modified flag.
- R4: A successful write access sets the slot's modified flag. `rsp_dirty` reports the flag as it stood before the current access.
- R5: A successful access sets the slot's referenced flag.
- R6: `victim_idx` is the lowest-numbered invalid slot when any slot is invalid.
- R7: When all slots are valid, `victim_idx` is the lowest-numbered slot whose referenced flag is clear.
- R8: When all slots are valid and referenced, `victim_idx` is 0 and every referenced flag is cleared at the next clock edge, except one set by an access taken in that same cycle.
- R9: `flush` invalidates every slot at the next edge, and it takes priority over a refill in the same cycle.
- R10: A refill writes page, frame and permission into slot `wr_idx`, marks it valid, and clears its referenced and modified flags.
- R11: If more than one valid slot matches, `multi_err` is asserted and no hit, fault or miss is reported.
- R12: `req_ready` is low whenever `flush` or `wr_en` is high. A request is taken, and `rsp_valid` asserted, only when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all slots |
| wr_en | input | 1 | Refill strobe |
| wr_idx | input | 4 | Slot to overwrite |
| wr_vpn | input | 20 | Virtual page to install |
| wr_ppn | input | 20 | Physical page to install |
| wr_perm | input | 2 | Permission code to install |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Lookup taken, response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address (zero unless hit) |
| rsp_dirty | output | 1 | Modified flag of the hit slot before this access |
| rsp_fault | output | 1 | Permission fault |
| trap_miss | output | 1 | Miss trap to software |
| trap_vpn | output | 20 | Page that missed (zero otherwise) |
| multi_err | output | 1 | More than one slot matched |
| victim_idx | output | 4 | Replacement hint |

## Verification
A corrupted valid flag or page field shows up at the ports on the very next lookup to that page, as a spurious miss, hit or multi-match. Reference-flag errors surface through `victim_idx` one edge after the access that should have set or cleared them. Modified-flag errors surface on the following hit to the same slot, through `rsp_dirty`. Permission decoding is exercised against every code with the access kinds that separate them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    PERM_RO   = 2'd0,
    PERM_RW   = 2'd1,
    PERM_RX   = 2'd2,
    PERM_NONE = 2'd3
  } perm_e;

  function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] acc);
    logic ok;
    case (perm)
      PERM_RO: ok = (acc == ACC_READ);
      PERM_RW: ok = (acc == ACC_READ) || (acc == ACC_WRITE);
      PERM_RX: ok = (acc == ACC_READ) || (acc == ACC_EXEC);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [VPN_W-1:0]                wr_vpn,
  input  logic [PPN_W-1:0]                wr_ppn,
  input  logic [1:0]                      wr_perm,
  input  logic                            upd_en,
  input  logic [IDX_W-1:0]                upd_idx,
  input  logic                            upd_dirty,
  input  logic                            age_clear,
  output logic [ENTRIES-1:0]              valid_q,
  output logic [ENTRIES-1:0]              ref_q,
  output logic [ENTRIES-1:0]              dirty_q,
  output logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q,
  output logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q,
  output logic [ENTRIES-1:0][1:0]         perm_q
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic sel_wr, sel_upd;
    assign sel_wr  = wr_en && (wr_idx == IDX_W'(i));
    assign sel_upd = upd_en && (upd_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        ref_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        ppn_q[i]   <= '0;
        perm_q[i]  <= 2'd3;
      end else if (flush) begin
        valid_q[i] <= 1'b0;
      end else if (sel_wr) begin
        valid_q[i] <= 1'b1;
        ref_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= wr_vpn;
        ppn_q[i]   <= wr_ppn;
        perm_q[i]  <= wr_perm;
      end else begin
        if (sel_upd) begin
          ref_q[i] <= 1'b1;
          if (upd_dirty) dirty_q[i] <= 1'b1;
        end else if (age_clear) begin
          ref_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  input  logic [VPN_W-1:0]              look_vpn,
  output logic                          hit_any,
  output logic                          multi,
  output logic [IDX_W-1:0]              hit_idx
);
  localparam int CNT_W = IDX_W + 1;
  logic [ENTRIES-1:0] match_vec;
  logic [CNT_W-1:0]   cnt;
  logic               found;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = valid_q[i] && (vpn_q[i] == look_vpn);
  end

  always_comb begin
    cnt     = '0;
    found   = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        cnt = cnt + CNT_W'(1);
        if (!found) begin
          hit_idx = IDX_W'(i);
          found   = 1'b1;
        end
      end
    end
  end

  assign hit_any = found;
  assign multi   = (cnt > CNT_W'(1));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] ref_q,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               age_clear
);
  logic got_free, got_cold;
  logic [IDX_W-1:0] free_idx, cold_idx;

  always_comb begin
    got_free = 1'b0;
    got_cold = 1'b0;
    free_idx = '0;
    cold_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        got_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (!ref_q[i]) begin
        got_cold = 1'b1;
        cold_idx = IDX_W'(i);
      end
    end
  end

  assign age_clear  = !got_free && !got_cold;
  assign victim_idx = got_free ? free_idx : (got_cold ? cold_idx : '0);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_perm,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_dirty,
  output logic             rsp_fault,
  output logic             trap_miss,
  output logic [VPN_W-1:0] trap_vpn,
  output logic             multi_err,
  output logic [IDX_W-1:0] victim_idx
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0]            valid_q, ref_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][1:0]       perm_q;
  logic                          hit_any, multi, age_clear, take, allowed, good;
  logic [IDX_W-1:0]              hit_idx;
  logic [VPN_W-1:0]              look_vpn;

  assign req_ready = !(flush || wr_en);
  assign take      = req_valid && req_ready;
  assign look_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
  assign allowed   = perm_allows(perm_q[hit_idx], req_acc);
  assign good      = take && hit_any && !multi;

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
    .upd_en(rsp_hit), .upd_idx(hit_idx), .upd_dirty(req_acc == ACC_WRITE),
    .age_clear(age_clear),
    .valid_q(valid_q), .ref_q(ref_q), .dirty_q(dirty_q),
    .vpn_q(vpn_q), .ppn_q(ppn_q), .perm_q(perm_q)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_match (
    .valid_q(valid_q), .vpn_q(vpn_q), .look_vpn(look_vpn),
    .hit_any(hit_any), .multi(multi), .hit_idx(hit_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_q(valid_q), .ref_q(ref_q),
    .victim_idx(victim_idx), .age_clear(age_clear)
  );

  assign rsp_valid = take;
  assign rsp_hit   = good && allowed;
  assign rsp_fault = good && !allowed;
  assign trap_miss = take && !hit_any;
  assign multi_err = take && multi;
  assign trap_vpn  = trap_miss ? look_vpn : '0;
  assign rsp_paddr = rsp_hit ? {ppn_q[hit_idx], req_vaddr[PAGE_BITS-1:0]} : '0;
  assign rsp_dirty = rsp_hit ? dirty_q[hit_idx] : 1'b0;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 wr_en,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [VA_W-1:0]      req_vaddr,
  input logic                 rsp_valid,
  input logic                 rsp_hit,
  input logic [PA_W-1:0]      rsp_paddr,
  input logic                 rsp_fault,
  input logic                 trap_miss,
  input logic [VA_W-PAGE_BITS-1:0] trap_vpn,
  input logic                 multi_err,
  input logic [IDX_W-1:0]     victim_idx
);
  a_r12_maint_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || wr_en) |-> (!req_ready && !rsp_valid));

  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_valid);

  a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_paddr[PAGE_BITS-1:0] == req_vaddr[PAGE_BITS-1:0]));

  a_r2_trap_page: assert property (@(posedge clk) disable iff (!rst_n)
    trap_miss |-> (trap_vpn == req_vaddr[VA_W-1:PAGE_BITS]));

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_fault, trap_miss, multi_err}) == 1));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (victim_idx == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .trap_miss(trap_miss), .trap_vpn(trap_vpn),
  .multi_err(multi_err), .victim_idx(victim_idx)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, wr_en = 0, req_valid = 0;
  logic [3:0]  wr_idx = 0;
  logic [19:0] wr_vpn = 0, wr_ppn = 0;
  logic [1:0]  wr_perm = 0, req_acc = 0;
  logic [31:0] req_vaddr = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_dirty, rsp_fault, trap_miss, multi_err;
  logic [31:0] rsp_paddr;
  logic [19:0] trap_vpn;
  logic [3:0]  victim_idx;

  int n_chk = 0, n_bad = 0;
  logic c_hit, c_fault, c_miss, c_multi, c_dirty, c_valid;
  logic [31:0] c_pa;
  logic [19:0] c_vpn;

  always #10 clk = ~clk;

  tlb_xlate u0 (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic refill(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [1:0] perm);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_perm = perm;
    #2 chk("R12 ready low during refill", req_ready, 0);
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    #2;
    c_valid = rsp_valid; c_hit = rsp_hit; c_fault = rsp_fault; c_miss = trap_miss;
    c_multi = multi_err; c_dirty = rsp_dirty; c_pa = rsp_paddr; c_vpn = trap_vpn;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic vic(input string tag, input int exp);
    @(negedge clk); #2 chk(tag, victim_idx, 64'(exp));
  endtask

  task automatic t_reset;
    vic("reset victim 0 (R6)", 0);
    chk("reset ready (R12)", req_ready, 1);
    look(32'h1234_5678, 2'd0);
    chk("R2 miss after reset", c_miss, 1);
    chk("R2 trap page", c_vpn, 20'h12345);
  endtask

  task automatic t_translate;
    refill(3, 20'h12345, 20'hABCDE, 2'd1);
    look(32'h1234_5678, 2'd0);
    chk("R1 hit", c_hit, 1);
    chk("R1 paddr", c_pa, 32'hABCD_E678);
    refill(5, 20'h00001, 20'h00FFF, 2'd2);
    look(32'h0000_1FFF, 2'd2);
    chk("R1 exec paddr", c_pa, 32'h00FF_FFFF);
  endtask

  task automatic t_miss;
    look(32'h5555_5000, 2'd1);
    chk("R2 miss", c_miss, 1);
    chk("R2 vpn", c_vpn, 20'h55555);
    chk("R2 no hit", c_hit, 0);
  endtask

  task automatic t_perm;
    look(32'h1234_5000, 2'd2);
    chk("R3 exec on rw faults", c_fault, 1);
    look(32'h0000_1000, 2'd1);
    chk("R3 write on rx faults", c_fault, 1);
    refill(7, 20'h00777, 20'h00123, 2'd0);
    look(32'h0077_7000, 2'd1);
    chk("R3 write on ro faults", c_fault, 1);
    look(32'h0077_7004, 2'd0);
    chk("R3 read on ro hits", c_hit, 1);
    refill(8, 20'h00888, 20'h00456, 2'd3);
    look(32'h0088_8000, 2'd0);
    chk("R3 no-access faults", c_fault, 1);
    look(32'h0088_8000, 2'd2);
    chk("R3 no-access exec faults", c_fault, 1);
  endtask

  task automatic t_dirty;
    look(32'h1234_5000, 2'd0);
    chk("R4 clean after fault", c_dirty, 0);
    look(32'h1234_5010, 2'd1);
    chk("R4 write hit", c_hit, 1);
    chk("R4 dirty before write", c_dirty, 0);
    look(32'h1234_5020, 2'd0);
    chk("R4 dirty after write", c_dirty, 1);
  endtask

  task automatic t_victim_free;
    vic("R6 lowest invalid", 0);
    refill(0, 20'h00AAA, 20'h00BBB, 2'd1);
    vic("R6 next invalid", 1);
  endtask

  task automatic t_flush;
    @(negedge clk);
    flush = 1; wr_en = 1; wr_idx = 4'd9; wr_vpn = 20'h00999; wr_perm = 2'd1;
    #2 chk("R12 ready low on flush", req_ready, 0);
    @(posedge clk); #1 flush = 0; wr_en = 0;
    vic("R9 all empty", 0);
    look(32'h1234_5000, 2'd0);
    chk("R9 miss after flush", c_miss, 1);
    look(32'h0099_9000, 2'd0);
    chk("R9 refill lost to flush", c_miss, 1);
  endtask

  task automatic t_lru;
    for (int i = 0; i < 16; i++) refill(i, 20'(32'h100 + i), 20'(32'h200 + i), 2'd1);
    vic("R7 all valid none referenced", 0);
    for (int i = 0; i < 3; i++) look({20'(32'h100 + i), 12'h0}, 2'd0);
    vic("R5 R7 three referenced", 3);
    look({20'h00103, 12'h0}, 2'd2);
    chk("R3 fault on rw exec", c_fault, 1);
    vic("R3 fault leaves ref clear", 3);
    for (int i = 3; i < 16; i++) look({20'(32'h100 + i), 12'h0}, 2'd0);
    vic("R8 all referenced hint 0", 0);
    look({20'h00100, 12'h0}, 2'd0);
    vic("R8 flags cleared", 1);
  endtask

  task automatic t_rewrite;
    look({20'h00100, 12'h004}, 2'd1);
    vic("R10 pre victim", 1);
    refill(0, 20'h00300, 20'h003AA, 2'd0);
    vic("R10 ref cleared", 0);
    look({20'h00100, 12'h0}, 2'd0);
    chk("R10 old page gone", c_miss, 1);
    look({20'h00300, 12'h0C4}, 2'd0);
    chk("R10 new paddr", c_pa, 32'h003A_A0C4);
    chk("R10 dirty cleared", c_dirty, 0);
  endtask

  task automatic t_multi;
    refill(2, 20'h00300, 20'h00777, 2'd1);
    look({20'h00300, 12'h0}, 2'd0);
    chk("R11 multi flag", c_multi, 1);
    chk("R11 no hit", c_hit, 0);
    chk("R11 no miss", c_miss, 0);
    chk("R11 no fault", c_fault, 0);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd4; wr_vpn = 20'h00444; wr_perm = 2'd1;
    req_valid = 1; req_vaddr = 32'h0030_0000; req_acc = 2'd0;
    #2 chk("R12 not taken during refill", rsp_valid, 0);
    chk("R12 no trap during refill", trap_miss | multi_err, 0);
    @(posedge clk); #1 wr_en = 0; req_valid = 0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_translate();
    t_miss();
    t_perm();
    t_dirty();
    t_victim_free();
    t_flush();
    t_lru();
    t_rewrite();
    t_multi();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule